// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on an asynchronous serial line. A one-entry holding buffer sits in front of a shift register. Software-side logic writes a character into the buffer with a single-cycle strobe. The buffer passes the character to the shifter at the next bit boundary, so the next character can be queued while the current one is still going out.

The bit period is sixteen pulses of a clock-enable tick, which comes from an external programmable baud divider. Each frame carries a low start bit and seven or eight data bits, sent LSB first. An even or odd parity bit is optional, and the frame closes with one or two high stop bits. Two status flags are reported: buffer empty and shift complete. A select input picks which of the two raises the transmit interrupt.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While `rst_ni` is low and after reset, `txd_o`, `tbe_o` and `tsc_o` are 1 and `irq_o` is 0.
- R2: A free-running prescaler counts `tick_i` pulses modulo 16. A bit boundary is the cycle in which `tick_i` is high and the count is 15. `txd_o` changes only on the clock edge that ends a boundary cycle.
- R3: A frame is sent in this order: one start bit (0), then the data bits LSB first, then the optional parity bit, then the stop bits (1). There are 8 data bits when `len8_i`=1 and 7 (bits 6:0) when `len8_i`=0. A parity bit is present when `par_en_i`=1. There are 2 stop bits when `stop2_i`=1 and 1 otherwise. The format inputs are sampled when a frame starts, and the line idles at 1.
- R4: The parity bit is the XOR of the data bits actually sent when `par_odd_i`=0 (even parity), and its inverse when `par_odd_i`=1.
- R5: When `wr_i` is high, `wr_data_i` enters the holding buffer and `tbe_o` is 0 from the next cycle. A write to a full buffer replaces the character it holds.
- R6: At a bit boundary where the buffer is full and the shifter is idle or ending its last stop bit, the character moves to the shifter. The start bit appears and `tbe_o` returns to 1 on that same edge, so back-to-back frames leave no idle gap.
- R7: A write made while `tsc_o`=1 clears `tsc_o` at the next bit boundary, when the start bit begins.
- R8: `tsc_o` rises at the boundary that begins the final stop bit (the second stop bit in two-stop mode), but only if the buffer is empty at that moment. Otherwise it stays 0.
- R9: `irq_o` is a one-cycle pulse in the first cycle that the selected flag reads 1: `tbe_o` when `irq_sel_i`=0, `tsc_o` when `irq_sel_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud divider clock-enable, 16 per bit |
| wr_i | input | 1 | Holding buffer write strobe |
| wr_data_i | input | 8 | Character to send |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| irq_sel_i | input | 1 | Interrupt source: 0 buffer empty, 1 shift complete |
| txd_o | output | 1 | Serial line |
| tbe_o | output | 1 | Holding buffer empty |
| tsc_o | output | 1 | Shift complete |
| irq_o | output | 1 | Transmit interrupt pulse |

## Verification
Every output and flag is a register, except the interrupt, which is derived from registered flags. Each result is therefore due exactly one clock edge after the cycle that causes it. `tbe_o` drops one edge after a write. `txd_o`, a rising `tbe_o` and both edges of `tsc_o` follow the edge that closes a boundary cycle. `irq_o` is high during the first cycle a selected flag reads 1. A behavioural reference model advances on each rising edge from the same inputs. The outputs are compared against it on every falling edge, and inputs are changed only after that comparison.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned STOP_MAX = 2;
  localparam int unsigned FRAME_W  = 1 + DATA_W + 1 + STOP_MAX;
  localparam int unsigned CNT_W    = $clog2(FRAME_W);

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  // LSB = first bit on the line; unused upper positions stay 1 (stop level)
  function automatic logic [FRAME_W-1:0] frame_build(logic [DATA_W-1:0] d, fmt_t f);
    logic [FRAME_W-1:0] v;
    logic p;
    int unsigned n;
    n = f.len8 ? DATA_W : DATA_W - 1;
    v = '1;
    v[0] = 1'b0;
    p = f.par_odd;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        v[i+1] = d[i];
        p = p ^ d[i];
      end
    end
    if (f.par_en) v[n+1] = p;
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(fmt_t f);
    int unsigned n;
    n = 2 + (f.len8 ? DATA_W : DATA_W - 1) + (f.par_en ? 1 : 0) + (f.stop2 ? 1 : 0);
    return CNT_W'(n);
  endfunction
endpackage

// File: rtl/tx_prescale.sv
module tx_prescale #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bound_o
);
  localparam int unsigned CW = $clog2(OVS);
  logic [CW-1:0] cnt_q;

  assign bound_o = tick_i && (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= bound_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_holdbuf.sv
module tx_holdbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      // a write in the take cycle lands after the old value is taken
      full_o <= wr_i | (full_o & ~take_i);
      if (wr_i) data_o <= wr_data_i;
    end
  end

  assert_full_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bound_i,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  fmt_t              fmt_i,
  output logic              take_o,
  output logic              txd_o,
  output logic              tsc_o
);
  logic               active_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   rem_q;
  logic               last_bit;

  assign last_bit = active_q && (rem_q == '0);
  assign take_o   = bound_i && buf_full_i && (!active_q || last_bit);
  assign txd_o    = frame_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      rem_q    <= '0;
      tsc_o    <= 1'b1;
    end else if (take_o) begin
      active_q <= 1'b1;
      frame_q  <= frame_build(buf_data_i, fmt_i);
      rem_q    <= frame_len(fmt_i) - 1'b1;
      tsc_o    <= 1'b0;
    end else if (bound_i && active_q) begin
      if (last_bit) begin
        active_q <= 1'b0;
        frame_q  <= '1;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        rem_q   <= rem_q - 1'b1;
        // entering final stop bit with nothing queued
        if (rem_q == CNT_W'(1) && !buf_full_i) tsc_o <= 1'b1;
      end
    end
  end

  assert_tsc_line_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsc_o |-> txd_o);
  assert_line_on_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(bound_i));
  assert_tsc_falls_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tsc_o) |-> !txd_o);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              len8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              irq_sel_i,
  output logic              txd_o,
  output logic              tbe_o,
  output logic              tsc_o,
  output logic              irq_o
);
  logic              bound;
  logic              take;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              tbe_prev_q, tsc_prev_q;
  fmt_t              fmt;

  assign fmt = '{len8: len8_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};

  tx_prescale #(.OVS(OVS)) u_pre (
    .clk_i, .rst_ni, .tick_i, .bound_o(bound)
  );

  tx_holdbuf #(.DW(DATA_W)) u_buf (
    .clk_i, .rst_ni, .wr_i, .wr_data_i, .take_i(take),
    .full_o(buf_full), .data_o(buf_data)
  );

  tx_shifter u_shift (
    .clk_i, .rst_ni, .bound_i(bound), .buf_full_i(buf_full), .buf_data_i(buf_data),
    .fmt_i(fmt), .take_o(take), .txd_o, .tsc_o
  );

  assign tbe_o = ~buf_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbe_prev_q <= 1'b1;
      tsc_prev_q <= 1'b1;
    end else begin
      tbe_prev_q <= tbe_o;
      tsc_prev_q <= tsc_o;
    end
  end

  assign irq_o = irq_sel_i ? (tsc_o & ~tsc_prev_q) : (tbe_o & ~tbe_prev_q);

  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $stable(irq_sel_i) |=> !irq_o);
  assert_tbe_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !tbe_o);
  assert_tbe_rise_on_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tbe_o) |-> $past(bound) && !txd_o);
endmodule

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdat = 8'h00;
  logic       len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, sel = 1'b0;
  logic       txd, tbe, tsc, irq;

  always #2 clk = ~clk;  // 250 MHz

  uart_tx_dbuf uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdat),
    .len8_i(len8), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .irq_sel_i(sel), .txd_o(txd), .tbe_o(tbe), .tsc_o(tsc), .irq_o(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit timeout = 1'b0, fast_tick = 1'b0;

  // reference model
  int  m_pre;
  bit  m_full, m_active, m_tsc, m_tbe, m_tbe_prev, m_tsc_prev;
  bit [7:0] m_buf;
  bit  m_q[$];

  task automatic m_reset();
    m_pre = 0; m_full = 0; m_active = 0; m_tsc = 1; m_tbe = 1;
    m_tbe_prev = 1; m_tsc_prev = 1; m_buf = 0; m_q.delete();
  endtask

  task automatic m_load();
    bit p;
    int n;
    n = len8 ? 8 : 7;
    p = par_odd;
    m_q.delete();
    m_q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      m_q.push_back(m_buf[i]);
      p ^= m_buf[i];
    end
    if (par_en) m_q.push_back(p);
    m_q.push_back(1'b1);
    if (stop2) m_q.push_back(1'b1);
    m_active = 1; m_tsc = 0; m_full = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      bit bnd, ld;
      m_tbe_prev = m_tbe;
      m_tsc_prev = m_tsc;
      bnd = tick && (m_pre == 15);
      if (tick) m_pre = (m_pre + 1) % 16;
      ld = 0;
      if (bnd) begin
        if (m_active) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_full) ld = 1; else m_active = 0;
          end else if (m_q.size() == 1 && !m_full) m_tsc = 1;
        end else if (m_full) ld = 1;
      end
      if (ld) m_load();
      if (wr) begin
        m_buf = wdat;
        m_full = 1;
      end
      m_tbe = !m_full;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  // compare on falling edge, then let the caller drive
  task automatic step();
    bit exp_txd, exp_irq;
    @(negedge clk);
    cyc++;
    exp_txd = m_active ? m_q[0] : 1'b1;
    exp_irq = sel ? (m_tsc && !m_tsc_prev) : (m_tbe && !m_tbe_prev);
    check("R2 R3 R4 R6", "txd", txd, exp_txd);
    check("R5 R6", "tbe", tbe, m_tbe);
    check("R7 R8", "tsc", tsc, m_tsc);
    check("R9", "irq", irq, exp_irq);
    tick = fast_tick ? 1'b1 : ~tick;
    if (cyc > 150000) timeout = 1'b1;
  endtask

  task automatic write(logic [7:0] d);
    wr = 1'b1; wdat = d;
    step();
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    while ((m_active || m_full) && !timeout) step();
    repeat (20) step();
  endtask

  task automatic wait_tbe();
    while (!m_tbe && !timeout) step();
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "txd in reset", txd, 1'b1);
    check("R1", "tbe in reset", tbe, 1'b1);
    check("R1", "tsc in reset", tsc, 1'b1);
    check("R1", "irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    repeat (5) step();

    // all eight formats, both parity types, interrupt on buffer empty (R3 R4)
    sel = 1'b0;
    for (int f = 0; f < 8; f++) begin
      len8 = f[0]; par_en = f[1]; stop2 = f[2]; par_odd = ~f[0];
      write(8'hA5 ^ 8'(f * 37));
      wait_idle();
    end

    // back-to-back frames, interrupt on shift complete (R6 R8)
    fast_tick = 1'b1;
    sel = 1'b1; len8 = 1'b1; par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b1;
    write(8'h3C);
    wait_tbe();
    write(8'hC3);
    wait_tbe();
    write(8'h81);
    wait_idle();

    // overwrite of a full buffer (R5)
    len8 = 1'b0; par_en = 1'b0; stop2 = 1'b0;
    write(8'h11);
    write(8'h7E);
    wait_tbe();
    write(8'h55);
    write(8'h2A);
    wait_idle();

    // write during final stop bit after shift complete rose (R7 R8)
    fast_tick = 1'b0;
    write(8'hF0);
    while (m_tsc && !timeout) step();
    while (!m_tsc && !timeout) step();
    repeat (7) step();
    write(8'h0F);
    wait_idle();

    // switch interrupt source while idle (R9)
    sel = 1'b0;
    repeat (4) step();
    write(8'h99);
    wait_idle();

    if (timeout) begin
      fails++;
      checks++;
      $display("FAIL watchdog at cycle %0d: actual hung expected done", cyc);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule